// File: doc/BRIEF.md
# Drawing Command Packet Framer

This block sits at the front of a drawing pipeline and turns a flat stream of 32-bit command words into whole command packets. The first word of every packet carries its opcode in bits 31:24. The framer works out from that opcode how many words belong to the packet. When the last word has arrived, it raises a one-cycle boundary strobe together with the opcode, the total word count and flags that classify the packet. Until that last word arrives, no strobe is raised.

Line-strip packets have no fixed length. The framer follows them word by word until a terminator pattern appears. Image-transfer headers are framed as fixed three-word packets and flagged, so that a downstream pixel mover can take over. Environment-setting commands are one-word packets whose whole word is latched into a bank of eight environment registers. Thirteen status bits are taken from two of those registers. Textured polygon packets also update the texture-page field of environment register 1.

Top module: `cmd_framer`

## Requirements
- R1: After reset `pkt_valid` is 0, environment register i holds (0xE0+i) in bits 31:24 and zero below, and `status_lo` is 0.
- R2: The following opcodes have no parameter words and are emitted as packets of length 1: 0x00, 0x01, 0x03–0x1F, 0x6C–0x6F, 0x81–0x9F and 0xE0–0xFF.
- R3: Fixed-length opcodes total 1 + N words. Fill 0x02 has N=2 and 0x80 has N=3. Over 0x20–0x3F, N per group of four is 3,6,4,8,5,8,7,11. Over 0x40–0x7F, N per group of four is 2,2,3,3,3,3,4,4,2,3,1,0,1,2,1,2.
- R4: `pkt_valid` is high for exactly the one cycle after the clock edge that accepts a packet's last word. It stays low while a packet is incomplete.
- R5: For flat line strips 0x48–0x4F, every word from index 3 onward is compared with the terminator, which is a word with (w & 0xF000F000) == 0x50005000. The packet ends with the first match, and the terminator is counted in its length.
- R6: For shaded line strips 0x58–0x5F, only the words at even indices 4, 6, 8, … are compared with the terminator. A matching word at an odd index does not end the packet.
- R7: Opcodes 0xA0–0xDF are three-word packets with `pkt_image` set. `pkt_read` is set only for 0xC0–0xDF.
- R8: An opcode in 0xE0–0xE7 stores its entire word into environment register (opcode & 7) at the edge that accepts it. The other registers keep their values.
- R9: `status_lo[10:0]` equals environment register 1 bits 10:0, and `status_lo[12:11]` equals environment register 6 bits 1:0.
- R10: The textured opcodes are those in 0x20–0x3F with bit 2 set. For them, bits 8:0 of the word at index 4 (bit 4 of the opcode clear) or index 5 (bit 4 set) replace environment register 1 bits 8:0.
- R11: A cycle with `in_valid` low advances nothing: no strobe, no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word present this cycle |
| in_word | input | 32 | Command word |
| pkt_valid | output | 1 | One-cycle packet boundary strobe |
| pkt_opcode | output | 8 | Opcode of the finished packet |
| pkt_len | output | CNT_W | Total words in the finished packet |
| pkt_image | output | 1 | Packet is an image-transfer header |
| pkt_read | output | 1 | Image transfer reads from memory |
| status_lo | output | 13 | Status bits taken from environment registers |
| env_regs | output | 256 | Environment registers, register i at bits 32i+31:32i |

## Verification
On every cycle, the assertions check several invariants of the framed output. Image packets are three words long, and reads are a subset of images. Environment packets are one word long, and fill packets are three. Flat line strips are never shorter than four words. A strobe always follows an accepted word, and an environment write to register 1 appears on the status bits one cycle later. Only the bench's scenarios can show the exact length for each opcode, the terminator positions that do and do not end a line strip, the texture-page capture, and that the framer holds its place across idle gaps in the middle of a packet.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int WORD_W = 32;
  localparam int ENV_N  = 8;
  localparam int OP_W   = 8;
  localparam logic [WORD_W-1:0] TERM_MASK  = 32'hF000_F000;
  localparam logic [WORD_W-1:0] TERM_MATCH = 32'h5000_5000;

  typedef enum logic [1:0] {
    ST_HEAD = 2'd0,
    ST_BODY = 2'd1,
    ST_POLY = 2'd2
  } fr_state_e;

  typedef struct packed {
    logic [3:0] n_param;
    logic       poly;
    logic       shaded;
    logic       image;
    logic       rd;
    logic       env;
    logic       textured;
    logic [2:0] tp_index;
  } op_info_t;
endpackage

// File: rtl/framer_len_lut.sv
module framer_len_lut
  import framer_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_info_t        info
);
  logic [3:0] n_poly;
  logic [3:0] n_prim;

  always_comb begin
    case (op[4:2])
      3'd0: n_poly = 4'd3;
      3'd1: n_poly = 4'd6;
      3'd2: n_poly = 4'd4;
      3'd3: n_poly = 4'd8;
      3'd4: n_poly = 4'd5;
      3'd5: n_poly = 4'd8;
      3'd6: n_poly = 4'd7;
      default: n_poly = 4'd11;
    endcase
  end

  always_comb begin
    case (op[5:2])
      4'h0, 4'h1, 4'h8, 4'hD, 4'hF: n_prim = 4'd2;
      4'h2, 4'h3, 4'h4, 4'h5, 4'h9: n_prim = 4'd3;
      4'h6, 4'h7:                   n_prim = 4'd4;
      4'hA, 4'hC, 4'hE:             n_prim = 4'd1;
      default:                      n_prim = 4'd0;
    endcase
  end

  always_comb begin
    case (op[7:5])
      3'b000:         info.n_param = (op == 8'h02) ? 4'd2 : 4'd0;
      3'b001:         info.n_param = n_poly;
      3'b010, 3'b011: info.n_param = n_prim;
      3'b100:         info.n_param = (op == 8'h80) ? 4'd3 : 4'd0;
      3'b101, 3'b110: info.n_param = 4'd2;
      default:        info.n_param = 4'd0;
    endcase
    info.poly     = (op[7:5] == 3'b010) && op[3];
    info.shaded   = (op[7:5] == 3'b010) && op[3] && op[4];
    info.image    = (op[7:5] == 3'b101) || (op[7:5] == 3'b110);
    info.rd       = (op[7:5] == 3'b110);
    info.env      = (op[7:3] == 5'b11100);
    info.textured = (op[7:5] == 3'b001) && op[2];
    info.tp_index = op[4] ? 3'd5 : 3'd4;
  end
endmodule

// File: rtl/framer_env_bank.sv
module framer_env_bank
  import framer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    env_we,
  input  logic [2:0]              env_idx,
  input  logic                    tp_we,
  input  logic [WORD_W-1:0]       wdata,
  output logic [ENV_N*WORD_W-1:0] env_flat,
  output logic [12:0]             status_lo
);
  logic [WORD_W-1:0] env_q [ENV_N];

  for (genvar i = 0; i < ENV_N; i++) begin : g_env
    localparam logic [WORD_W-1:0] RST_VAL = {8'hE0 + 8'(i), 24'h0};
    logic              sel;
    logic [WORD_W-1:0] env_d;
    logic              env_en;

    assign sel = env_we && (env_idx == 3'(i));

    if (i == 1) begin : g_tp
      always_comb begin
        env_en = sel || tp_we;
        env_d  = sel ? wdata : {env_q[i][WORD_W-1:9], wdata[8:0]};
      end
    end else begin : g_plain
      always_comb begin
        env_en = sel;
        env_d  = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      env_q[i] <= RST_VAL;
      else if (env_en) env_q[i] <= env_d;
    end

    assign env_flat[i*WORD_W +: WORD_W] = env_q[i];
  end

  assign status_lo = {env_q[6][1:0], env_q[1][10:0]};
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  op_info_t          info,
  output logic [OP_W-1:0]   lut_op,
  output logic              env_we,
  output logic              tp_we,
  output logic              at_head,
  output logic              pkt_valid,
  output logic [OP_W-1:0]   pkt_opcode,
  output logic [CNT_W-1:0]  pkt_len,
  output logic              pkt_image,
  output logic              pkt_read
);
  fr_state_e        st_q, st_n;
  logic [OP_W-1:0]  op_q, op_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [3:0]       rem_q, rem_n;
  logic             skip_q, skip_n;
  logic             emit;
  logic             term;

  assign at_head = (st_q == ST_HEAD);
  assign lut_op  = at_head ? in_word[31:24] : op_q;
  assign term    = (in_word & TERM_MASK) == TERM_MATCH;

  always_comb begin
    st_n   = st_q;
    op_n   = op_q;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    skip_n = skip_q;
    emit   = 1'b0;
    env_we = 1'b0;
    tp_we  = 1'b0;
    if (in_valid) begin
      case (st_q)
        ST_HEAD: begin
          op_n   = in_word[31:24];
          cnt_n  = CNT_W'(1);
          env_we = info.env;
          if (info.n_param == 4'd0) begin
            emit = 1'b1;
          end else begin
            st_n  = ST_BODY;
            rem_n = info.n_param - 4'(info.poly);
          end
        end
        ST_BODY: begin
          cnt_n = cnt_q + CNT_W'(1);
          tp_we = info.textured && (cnt_q == CNT_W'(info.tp_index));
          rem_n = rem_q - 4'd1;
          if (rem_q == 4'd1) begin
            if (info.poly) begin
              st_n   = ST_POLY;
              skip_n = 1'b0;
            end else begin
              emit = 1'b1;
              st_n = ST_HEAD;
            end
          end
        end
        ST_POLY: begin
          cnt_n = cnt_q + CNT_W'(1);
          if (!skip_q && term) begin
            emit = 1'b1;
            st_n = ST_HEAD;
          end else if (info.shaded) begin
            skip_n = ~skip_q;
          end
        end
        default: st_n = ST_HEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HEAD;
      op_q   <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      skip_q <= 1'b0;
    end else if (in_valid) begin
      st_q   <= st_n;
      op_q   <= op_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      skip_q <= skip_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_valid <= 1'b0;
    else        pkt_valid <= emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_opcode <= '0;
      pkt_len    <= '0;
      pkt_image  <= 1'b0;
      pkt_read   <= 1'b0;
    end else if (emit) begin
      pkt_opcode <= lut_op;
      pkt_len    <= cnt_n;
      pkt_image  <= info.image;
      pkt_read   <= info.rd;
    end
  end
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
  import framer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_word,
  output logic                    pkt_valid,
  output logic [OP_W-1:0]         pkt_opcode,
  output logic [CNT_W-1:0]        pkt_len,
  output logic                    pkt_image,
  output logic                    pkt_read,
  output logic [12:0]             status_lo,
  output logic [ENV_N*WORD_W-1:0] env_regs
);
  op_info_t        info;
  logic [OP_W-1:0] lut_op;
  logic            env_we;
  logic            tp_we;
  logic            at_head;

  framer_len_lut u_lut (
    .op   (lut_op),
    .info (info)
  );

  framer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .info       (info),
    .lut_op     (lut_op),
    .env_we     (env_we),
    .tp_we      (tp_we),
    .at_head    (at_head),
    .pkt_valid  (pkt_valid),
    .pkt_opcode (pkt_opcode),
    .pkt_len    (pkt_len),
    .pkt_image  (pkt_image),
    .pkt_read   (pkt_read)
  );

  framer_env_bank u_env (
    .clk       (clk),
    .rst_n     (rst_n),
    .env_we    (env_we),
    .env_idx   (in_word[26:24]),
    .tp_we     (tp_we),
    .wdata     (in_word),
    .env_flat  (env_regs),
    .status_lo (status_lo)
  );
endmodule

// File: rtl/cmd_framer_chk.sv
module cmd_framer_chk
  import framer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              at_head,
  input logic              pkt_valid,
  input logic [OP_W-1:0]   pkt_opcode,
  input logic [CNT_W-1:0]  pkt_len,
  input logic              pkt_image,
  input logic              pkt_read,
  input logic [12:0]       status_lo
);
  p_image_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_image |-> pkt_len == CNT_W'(3) &&
      (pkt_opcode[7:5] == 3'b101 || pkt_opcode[7:5] == 3'b110));

  p_read_is_image_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_read |-> pkt_image && pkt_opcode[7:5] == 3'b110);

  p_env_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_opcode[7:3] == 5'b11100 |-> pkt_len == CNT_W'(1));

  p_env1_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && at_head && in_word[31:24] == 8'hE1 |=>
      status_lo[10:0] == $past(in_word[10:0]));

  p_env6_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && at_head && in_word[31:24] == 8'hE6 |=>
      status_lo[12:11] == $past(in_word[1:0]));

  p_strobe_after_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> $past(in_valid));

  p_fill_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_opcode == 8'h02 |-> pkt_len == CNT_W'(3));

  p_flat_strip_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_opcode[7:3] == 5'b01001 |-> pkt_len >= CNT_W'(4));
endmodule

bind cmd_framer cmd_framer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_word    (in_word),
  .at_head    (at_head),
  .pkt_valid  (pkt_valid),
  .pkt_opcode (pkt_opcode),
  .pkt_len    (pkt_len),
  .pkt_image  (pkt_image),
  .pkt_read   (pkt_read),
  .status_lo  (status_lo)
);

// File: tb/tb_cmd_framer.sv
module tb_cmd_framer;
  localparam int CNT_W = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [31:0]       in_word;
  logic              pkt_valid;
  logic [7:0]        pkt_opcode;
  logic [CNT_W-1:0]  pkt_len;
  logic              pkt_image;
  logic              pkt_read;
  logic [12:0]       status_lo;
  logic [255:0]      env_regs;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [31:0] m_env [8];

  always #10 clk = ~clk;

  cmd_framer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .pkt_valid(pkt_valid), .pkt_opcode(pkt_opcode), .pkt_len(pkt_len),
    .pkt_image(pkt_image), .pkt_read(pkt_read), .status_lo(status_lo),
    .env_regs(env_regs)
  );

  function automatic int exp_params(logic [7:0] op);
    if (op == 8'h02)      return 2;
    if (op <  8'h20)      return 0;
    if (op <  8'h24)      return 3;
    if (op <  8'h28)      return 6;
    if (op <  8'h2C)      return 4;
    if (op <  8'h30)      return 8;
    if (op <  8'h34)      return 5;
    if (op <  8'h38)      return 8;
    if (op <  8'h3C)      return 7;
    if (op <  8'h40)      return 11;
    if (op <  8'h48)      return 2;
    if (op <  8'h58)      return 3;
    if (op <  8'h60)      return 4;
    if (op <  8'h64)      return 2;
    if (op <  8'h68)      return 3;
    if (op <  8'h6C)      return 1;
    if (op <  8'h70)      return 0;
    if (op <  8'h74)      return 1;
    if (op <  8'h78)      return 2;
    if (op <  8'h7C)      return 1;
    if (op <  8'h80)      return 2;
    if (op == 8'h80)      return 3;
    if (op >= 8'hA0 && op <= 8'hDF) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_env(string req);
    for (int i = 0; i < 8; i++)
      check(env_regs[i*32 +: 32] == m_env[i], req, $sformatf("env reg %0d", i),
            64'(env_regs[i*32 +: 32]), 64'(m_env[i]));
    check(status_lo == {m_env[6][1:0], m_env[1][10:0]}, "R9", "status_lo",
          64'(status_lo), 64'({m_env[6][1:0], m_env[1][10:0]}));
  endtask

  // Called at a falling edge; applies one word and checks the strobe one edge later.
  task automatic push(logic [31:0] w, bit last, logic [7:0] op, int len, string req);
    bit img;
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    img = (op >= 8'hA0 && op <= 8'hDF);
    if (last) begin
      check(pkt_valid == 1'b1, req, "strobe at last word", 64'(pkt_valid), 64'd1);
      check(pkt_opcode == op, req, "opcode", 64'(pkt_opcode), 64'(op));
      check(pkt_len == CNT_W'(len), req, "length", 64'(pkt_len), 64'(len));
      check(pkt_image == img, "R7", "image flag", 64'(pkt_image), 64'(img));
      check(pkt_read == (op >= 8'hC0 && op <= 8'hDF), "R7", "read flag",
            64'(pkt_read), 64'(op >= 8'hC0 && op <= 8'hDF));
    end else begin
      check(pkt_valid == 1'b0, "R4", "no strobe mid-packet", 64'(pkt_valid), 64'd0);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0;
      in_word  = $urandom;
      @(negedge clk);
      check(pkt_valid == 1'b0, "R11", "idle cycle strobe", 64'(pkt_valid), 64'd0);
    end
  endtask

  task automatic send_pkt(logic [7:0] op, int max_gap, string req);
    int n = exp_params(op) + 1;
    bit tex = (op >= 8'h20 && op <= 8'h3F && op[2]);
    int tpi = op[4] ? 5 : 4;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w = (i == 0) ? {op, 24'($urandom)} : $urandom;
      if (i == 0 && op >= 8'hE0 && op <= 8'hE7) m_env[op[2:0]] = w;
      if (tex && i == tpi) m_env[1][8:0] = w[8:0];
      push(w, i == n - 1, op, n, req);
      if (max_gap > 0) idle($urandom_range(max_gap, 0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m_env[i] = {8'hE0 + 8'(i), 24'h0};
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check(pkt_valid == 1'b0, "R1", "strobe after reset", 64'(pkt_valid), 64'd0);
    check_env("R1");

    // R2 single-word opcodes
    send_pkt(8'h00, 0, "R2");
    send_pkt(8'h6D, 0, "R2");
    send_pkt(8'h9A, 0, "R2");
    // R4: fill with gaps in the middle
    push({8'h02, 24'h123456}, 0, 8'h02, 3, "R4");
    idle(3);
    push(32'h0010_0020, 0, 8'h02, 3, "R4");
    idle(2);
    push(32'h0040_0080, 1, 8'h02, 3, "R4");
    // R3 fixed lengths incl. the longest and 0x80
    send_pkt(8'h3E, 1, "R3");
    send_pkt(8'h80, 1, "R3");
    send_pkt(8'h53, 0, "R3");
    // R8/R9 environment writes
    send_pkt(8'hE1, 0, "R8");
    send_pkt(8'hE6, 0, "R8");
    send_pkt(8'hE3, 0, "R8");
    check_env("R8");
    // R10 texture page capture: index 4 then index 5
    send_pkt(8'h2C, 1, "R10");
    check_env("R10");
    send_pkt(8'h36, 0, "R10");
    check_env("R10");
    // R7 image headers
    send_pkt(8'hA0, 1, "R7");
    send_pkt(8'hC5, 0, "R7");
    send_pkt(8'hDF, 0, "R7");
    // R5 flat strip: terminator at index 3
    push(32'h4800_0000, 0, 8'h48, 4, "R5");
    push(32'h0001_0001, 0, 8'h48, 4, "R5");
    push(32'h0002_0002, 0, 8'h48, 4, "R5");
    push(32'h5555_5555, 1, 8'h48, 4, "R5");
    // R5 flat strip: terminator at index 5
    push(32'h4A00_0000, 0, 8'h4A, 6, "R5");
    for (int i = 1; i < 5; i++) push(32'h0003_0004, 0, 8'h4A, 6, "R5");
    idle(1);
    push(32'h5000_5000, 1, 8'h4A, 6, "R5");
    // R6 shaded strip: terminator at index 4
    push(32'h5800_0000, 0, 8'h58, 5, "R6");
    for (int i = 1; i < 4; i++) push(32'h0000_0111, 0, 8'h58, 5, "R6");
    push(32'h5FFF_5FFF, 1, 8'h58, 5, "R6");
    // R6 shaded strip: pattern at odd index 5 ignored, ends at index 6
    push(32'h5E00_0000, 0, 8'h5E, 7, "R6");
    for (int i = 1; i < 5; i++) push(32'h0000_0222, 0, 8'h5E, 7, "R6");
    push(32'h5000_5000, 0, 8'h5E, 7, "R6");
    push(32'h5123_5456, 1, 8'h5E, 7, "R6");
    check_env("R11");

    // R3 random fixed-length traffic
    for (int p = 0; p < 400; p++) begin
      do op = 8'($urandom); while (op[7:5] == 3'b010 && op[3]);
      send_pkt(op, 2, "R3");
      if (p % 25 == 0) check_env("R8");
    end
    check_env("R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule